// File: doc/BRIEF.md
# Output Driver Mode and Lockout Supervisor

This block is the digital control core of one industrial channel that works either as a driver (high-side only, or push-pull) or as a current-sinking input. It turns three mode pins into registered enables for the high-side switch, the low-side switch and the input current sink, and it selects the sink strength. It also applies three protective lockouts to the two switches: thermal shutdown with hysteresis, time-qualified supply overvoltage, and immediate undervoltage.

The block is built around a five-state channel machine. Its states are `ST_HS` (high-side driver), `ST_PP` (push-pull driver), `ST_IN_T13` (input, low-current sink), `ST_IN_T2` (input, high-current sink) and `ST_LOCK` (driver requested but a lockout holds both switches off). Each clock edge picks the next state by priority. Input-enable high goes to `ST_IN_T2` when push-pull select is high and to `ST_IN_T13` when it is low. Otherwise, any active lockout goes to `ST_LOCK`. Otherwise push-pull select picks `ST_PP` (high) or `ST_HS` (low). Any state can reach any other in one edge.

Two helper machines feed the lockout. The thermal guard has states `TH_COOL` and `TH_HOT`. It moves from `TH_COOL` to `TH_HOT` when the temperature code reaches the trip value, and back when the code falls to the trip value minus the hysteresis or lower. The overvoltage qualifier is a saturating tick counter. The level-monitor output and the overvoltage status output pass straight through with no register.

Top module: `drvsup_top`

## Requirements
- R1: With input-enable low and push-pull select low, one edge later `hs_en` equals the sampled `din`, and `ls_en` stays 0.
- R2: With input-enable low and push-pull select high, one edge later `hs_en` equals `din` and `ls_en` equals its inverse. `hs_en` and `ls_en` are never both 1.
- R3: With input-enable high, one edge later both switch enables are 0 and `sink_en` is 1, whatever `din` is. `sink_en` is 0 in every other case. Lockouts do not disable the sink.
- R4: In input mode, `sink_hi` is 1 only when push-pull select is high and `hv_flag` is low; otherwise it is 0. The value shows one edge after the inputs are sampled.
- R5: `level_n` is always the inverse of `doi_cmp`, with no clock delay, in every mode and during reset.
- R6: The thermal lockout is set at the first edge where `temp_code` is at least TRIP_C (170). It clears at the first edge where `temp_code` is at most TRIP_C minus HYST_C (155). Between those values it keeps its state. The switch enables follow one edge after the lockout changes.
- R7: The overvoltage lockout is set at the edge that samples `ov_flag` high for the (QUAL_CYCLES+1)th edge in a row. A single low sample restarts the count and clears the lockout at that edge. The switch enables follow one edge later.
- R8: `ov_status` equals `ov_flag` combinationally, whatever the qualification state.
- R9: Any bit of `uv_flags` high at an edge forces both switch enables to 0 from that edge. The driver resumes at the edge after all bits are low.
- R10: While `rst_n` is low, `hs_en`, `ls_en`, `sink_en` and `sink_hi` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the overvoltage qualification tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| di_en | input | 1 | Input mode enable (1 = current-sinking input) |
| din | input | 1 | Data to drive in output mode |
| pp_sel | input | 1 | Push-pull select in output mode; sink strength select in input mode |
| uv_flags | input | UV_N | Supply undervoltage flags, one per supply |
| ov_flag | input | 1 | Supply overvoltage comparator flag (with analog hysteresis) |
| temp_code | input | TEMP_W | Die temperature in degrees C, unsigned |
| hv_flag | input | 1 | High input voltage flag |
| doi_cmp | input | 1 | Output-pin level comparator bit |
| hs_en | output | 1 | High-side switch enable |
| ls_en | output | 1 | Low-side switch enable |
| sink_en | output | 1 | Input current sink enable |
| sink_hi | output | 1 | High-current sink select |
| level_n | output | 1 | Inverted level monitor |
| ov_status | output | 1 | Overvoltage status, not qualified |

## Verification
The bench steps the overvoltage flag to exactly QUAL_CYCLES+1 samples and one more. A counter that is off by one cuts the switches one edge early or one edge late. It also drops the flag for a single cycle part-way through a count, which catches a counter that pauses instead of restarting. The thermal test holds the temperature at 156 and then 155. This exposes a release threshold that is off by one, and also a guard with no hysteresis that re-enables as soon as the code drops below 170. In push-pull, input and high-voltage cases it checks that the data pin, the sink selection and a lockout during input mode each reach only the outputs they should.

// File: rtl/drvsup_pkg.sv
package drvsup_pkg;

    typedef enum logic [2:0] {
        ST_HS     = 3'd0,
        ST_PP     = 3'd1,
        ST_IN_T13 = 3'd2,
        ST_IN_T2  = 3'd3,
        ST_LOCK   = 3'd4
    } chan_state_e;

    typedef enum logic {
        TH_COOL = 1'b0,
        TH_HOT  = 1'b1
    } therm_state_e;

endpackage

// File: rtl/drvsup_thermal.sv
module drvsup_thermal
    import drvsup_pkg::*;
#(
    parameter int TEMP_W = 8,
    parameter int TRIP_C = 170,
    parameter int HYST_C = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              hot
);
    localparam logic [TEMP_W-1:0] TRIP_CODE = TEMP_W'(TRIP_C);
    localparam logic [TEMP_W-1:0] REL_CODE  = TEMP_W'(TRIP_C - HYST_C);

    therm_state_e th_state, th_next;

    always_comb begin
        th_next = th_state;
        unique case (th_state)
            TH_COOL: if (temp_code >= TRIP_CODE) th_next = TH_HOT;
            TH_HOT:  if (temp_code <= REL_CODE)  th_next = TH_COOL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) th_state <= TH_COOL;
        else        th_state <= th_next;
    end

    assign hot = (th_state == TH_HOT);
endmodule

// File: rtl/drvsup_ovlo.sv
module drvsup_ovlo #(
    parameter int QUAL_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ov_flag,
    output logic ov_lock
);
    localparam int CW = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0] QUAL_MAX = CW'(QUAL_CYCLES);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            ov_lock <= 1'b0;
        end else if (!ov_flag) begin
            run_cnt <= '0;
            ov_lock <= 1'b0;
        end else if (run_cnt == QUAL_MAX) begin
            ov_lock <= 1'b1;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/drvsup_top.sv
module drvsup_top
    import drvsup_pkg::*;
#(
    parameter int UV_N        = 3,
    parameter int TEMP_W      = 8,
    parameter int TRIP_C      = 170,
    parameter int HYST_C      = 15,
    parameter int QUAL_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              di_en,
    input  logic              din,
    input  logic              pp_sel,
    input  logic [UV_N-1:0]   uv_flags,
    input  logic              ov_flag,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic              hv_flag,
    input  logic              doi_cmp,
    output logic              hs_en,
    output logic              ls_en,
    output logic              sink_en,
    output logic              sink_hi,
    output logic              level_n,
    output logic              ov_status
);
    logic        th_hot, ov_lock, lockout;
    logic        din_q, hv_q;
    chan_state_e state, state_next;

    drvsup_thermal #(.TEMP_W(TEMP_W), .TRIP_C(TRIP_C), .HYST_C(HYST_C)) u_thermal (
        .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .hot(th_hot)
    );

    drvsup_ovlo #(.QUAL_CYCLES(QUAL_CYCLES)) u_ovlo (
        .clk(clk), .rst_n(rst_n), .ov_flag(ov_flag), .ov_lock(ov_lock)
    );

    assign lockout = (|uv_flags) | ov_lock | th_hot;

    // Priority: input mode, then lockout, then driver style
    always_comb begin
        if (di_en)        state_next = pp_sel ? ST_IN_T2 : ST_IN_T13;
        else if (lockout) state_next = ST_LOCK;
        else if (pp_sel)  state_next = ST_PP;
        else              state_next = ST_HS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_LOCK;
            din_q <= 1'b0;
            hv_q  <= 1'b0;
        end else begin
            state <= state_next;
            din_q <= din;
            hv_q  <= hv_flag;
        end
    end

    always_comb begin
        hs_en   = 1'b0;
        ls_en   = 1'b0;
        sink_en = 1'b0;
        sink_hi = 1'b0;
        unique case (state)
            ST_HS:     hs_en = din_q;
            ST_PP: begin
                hs_en = din_q;
                ls_en = ~din_q;
            end
            ST_IN_T13: sink_en = 1'b1;
            ST_IN_T2: begin
                sink_en = 1'b1;
                sink_hi = ~hv_q;
            end
            ST_LOCK:   ;
            default:   ;
        endcase
    end

    assign level_n   = ~doi_cmp;
    assign ov_status = ov_flag;
endmodule

// File: rtl/drvsup_checker.sv
module drvsup_checker #(
    parameter int UV_N = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            di_en,
    input logic            pp_sel,
    input logic [UV_N-1:0] uv_flags,
    input logic            hv_flag,
    input logic            hs_en,
    input logic            ls_en,
    input logic            sink_en,
    input logic            sink_hi
);
    p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    p_hs_no_ls_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!di_en && !pp_sel) |=> !ls_en);

    p_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
        di_en |=> (sink_en && !hs_en && !ls_en));

    p_nosink_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !di_en |=> !sink_en);

    p_hv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hv_flag |=> !sink_hi);

    p_type2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (di_en && pp_sel && !hv_flag) |=> sink_hi);

    p_uv_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|uv_flags) |=> (!hs_en && !ls_en));

    always_comb begin
        if (!rst_n) begin
            p_reset_r10: assert (!hs_en && !ls_en && !sink_en && !sink_hi);
        end
    end
endmodule

bind drvsup_top drvsup_checker #(.UV_N(UV_N)) u_chk (.*);

// File: tb/drvsup_top_bench.sv
module drvsup_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int UV_N = 3;
    localparam int TEMP_W = 8;
    localparam int QUAL = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic di_en = 1'b0, din = 1'b0, pp_sel = 1'b0;
    logic [UV_N-1:0] uv_flags = '0;
    logic ov_flag = 1'b0;
    logic [TEMP_W-1:0] temp_code = 8'd25;
    logic hv_flag = 1'b0, doi_cmp = 1'b0;
    logic hs_en, ls_en, sink_en, sink_hi, level_n, ov_status;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    drvsup_top #(.UV_N(UV_N), .TEMP_W(TEMP_W), .QUAL_CYCLES(QUAL)) u_drvsup_top (
        .clk(clk), .rst_n(rst_n), .di_en(di_en), .din(din), .pp_sel(pp_sel),
        .uv_flags(uv_flags), .ov_flag(ov_flag), .temp_code(temp_code),
        .hv_flag(hv_flag), .doi_cmp(doi_cmp), .hs_en(hs_en), .ls_en(ls_en),
        .sink_en(sink_en), .sink_hi(sink_hi), .level_n(level_n), .ov_status(ov_status)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", tag, act, exp);
        end
    endtask

    // n rising edges, then settle at the falling edge
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [3:0] outs();
        return {hs_en, ls_en, sink_en, sink_hi};
    endfunction

    task automatic t_reset();
        #1;
        chk("R10 reset outputs", outs(), 4'b0000);
        chk("R5 level during reset", {3'b0, level_n}, 4'b0001);
        tick(1);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic t_highside();
        di_en = 0; pp_sel = 0; din = 1;
        tick(1);
        chk("R1 hs din=1", outs(), 4'b1000);
        din = 0;
        tick(1);
        chk("R1 hs din=0 tri-state", outs(), 4'b0000);
    endtask

    task automatic t_pushpull();
        pp_sel = 1; din = 1;
        tick(1);
        chk("R2 pp din=1", outs(), 4'b1000);
        din = 0;
        tick(1);
        chk("R2 pp din=0", outs(), 4'b0100);
    endtask

    task automatic t_input();
        di_en = 1; pp_sel = 0; din = 1;
        tick(1);
        chk("R3 input t13 din=1", outs(), 4'b0010);
        din = 0;
        tick(1);
        chk("R3 input din ignored", outs(), 4'b0010);
        pp_sel = 1;
        tick(1);
        chk("R4 type2 high sink", outs(), 4'b0011);
        hv_flag = 1;
        tick(1);
        chk("R4 type2 high voltage drops", outs(), 4'b0010);
        uv_flags = 3'b001;
        tick(1);
        chk("R3 sink kept under lockout", outs(), 4'b0010);
        uv_flags = '0; hv_flag = 0; di_en = 0; pp_sel = 0;
        tick(1);
        chk("R3 sink off in output mode", outs(), 4'b0000);
    endtask

    task automatic t_level();
        for (int i = 0; i < 4; i++) begin
            di_en = i[1]; doi_cmp = i[0];
            #1;
            chk("R5 level inverse", {3'b0, level_n}, {3'b0, ~i[0]});
            tick(1);
        end
        di_en = 0;
        tick(1);
    endtask

    task automatic t_thermal();
        pp_sel = 1; din = 1;
        temp_code = 8'd169;
        tick(3);
        chk("R6 169 no trip", outs(), 4'b1000);
        temp_code = 8'd170;
        tick(1);
        chk("R6 lockout registered one edge", outs(), 4'b1000);
        tick(1);
        chk("R6 trip at 170", outs(), 4'b0000);
        temp_code = 8'd156;
        tick(3);
        chk("R6 hold at 156", outs(), 4'b0000);
        temp_code = 8'd155;
        tick(2);
        chk("R6 release at 155", outs(), 4'b1000);
        temp_code = 8'd25;
    endtask

    task automatic t_ovlo();
        pp_sel = 0; din = 1;
        ov_flag = 1;
        #1;
        chk("R8 status immediate", {3'b0, ov_status}, 4'b0001);
        tick(QUAL + 1);
        chk("R7 not yet locked", outs(), 4'b1000);
        tick(1);
        chk("R7 locked after qualification", outs(), 4'b0000);
        ov_flag = 0;
        #1;
        chk("R8 status clears", {3'b0, ov_status}, 4'b0000);
        tick(2);
        chk("R7 recovery", outs(), 4'b1000);
        ov_flag = 1;
        tick(QUAL - 5);
        ov_flag = 0;
        tick(1);
        ov_flag = 1;
        tick(QUAL + 1);
        chk("R7 count restarted", outs(), 4'b1000);
        tick(1);
        chk("R7 locked after restart", outs(), 4'b0000);
        ov_flag = 0;
        tick(2);
    endtask

    task automatic t_uv();
        pp_sel = 1; din = 0;
        tick(1);
        chk("R9 pp baseline", outs(), 4'b0100);
        uv_flags = 3'b100;
        tick(1);
        chk("R9 uv off", outs(), 4'b0000);
        uv_flags = 3'b010;
        tick(1);
        chk("R9 other uv off", outs(), 4'b0000);
        uv_flags = '0;
        tick(1);
        chk("R9 resume", outs(), 4'b0100);
    endtask

    initial begin
        t_reset();
        t_highside();
        t_pushpull();
        t_input();
        t_level();
        t_thermal();
        t_ovlo();
        t_uv();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL R10 watchdog actual timeout expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule